// File: doc/BRIEF.md
# Branch History Rolling Buffer

This block is a circular store of 64-bit branch history records, with two access operations that a core can issue against it: clear-all and read-by-age. A record port writes each new entry into the slot named by a write pointer. That slot always holds the oldest entry. After the write, the pointer advances and wraps modulo the entry count. A read names an entry by its age, where selector 0 is the newest entry. The read returns that entry one cycle later, or returns zero when the feature is off, the selector is out of range, or performance-monitor alerts are enabled.

Both operations first pass a two-level permission check. The hypervisor-level enable is tested first. The problem-state check is tested second: user mode with the user-access enable clear fails it. A failed check blocks the operation and produces a one-cycle fault pulse. The pulse carries a fixed cause code and a bit that tells which level refused. A build option keeps no history at all. In that build the operations still run and check permissions, but every read returns zero.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset, the write pointer is 0, every entry is zero, and `rd_valid_o` and `fault_o` are low.
- R2: Each cycle with `rec_valid_i` high writes `rec_data_i` into the oldest slot and advances the pointer, wrapping after `NUM_ENTRIES` records. A following read with selector 0 returns that value.
- R3: A read with selector k (k < `NUM_ENTRIES`) returns the physical slot (pointer - (k + 1)) mod `NUM_ENTRIES`, which is the k-th record before the newest. This holds across pointer wrap-around, and slots never written read as zero.
- R4: An accepted read sets `rd_valid_o` high, with its data on `rd_data_o`, in the cycle after the request. A cycle without an accepted request leaves `rd_valid_o` low.
- R5: A read whose selector is greater than or equal to `NUM_ENTRIES` completes with `rd_data_o` equal to zero.
- R6: A read completes with zero data when `feature_en_i` is low or `alert_en_i` is high.
- R7: A permitted clear with `feature_en_i` high zeroes every entry and returns the pointer to 0. With `feature_en_i` low, a permitted clear changes nothing and raises no fault.
- R8: When a clear is executed and `rec_valid_i` is high in the same cycle, the clear wins and the record is dropped.
- R9: A read or clear issued with `hyp_en_i` low has no effect. In the next cycle it raises `fault_o` for exactly one cycle, with `fault_cause_o` equal to `FAULT_CAUSE` and `fault_hyp_o` = 1.
- R10: A read or clear issued with `user_mode_i` high and `user_avail_i` low has no effect and faults with `fault_hyp_o` = 0. When both checks fail, the hypervisor fault (`fault_hyp_o` = 1) is the one reported.
- R11: With `KEEP_HISTORY` = 0, permitted reads complete without a fault and always return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record a new entry this cycle |
| rec_data_i | input | DATA_W | Entry to record |
| clr_req_i | input | 1 | Clear-all request |
| rd_req_i | input | 1 | Read-by-age request |
| rd_sel_i | input | SEL_W | Age selector, 0 = newest |
| user_mode_i | input | 1 | Core is in problem (user) state |
| user_avail_i | input | 1 | Buffer access allowed in user state |
| hyp_en_i | input | 1 | Hypervisor-level facility enable |
| feature_en_i | input | 1 | Buffer feature present and enabled |
| alert_en_i | input | 1 | Performance-monitor alert enable |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | DATA_W | Read result |
| fault_o | output | 1 | Facility-unavailable fault pulse |
| fault_cause_o | output | CAUSE_W | Fault cause code, zero when no fault |
| fault_hyp_o | output | 1 | Fault raised by the hypervisor-level check |

## Verification
The bench builds the main instance with `NUM_ENTRIES` = 6. A count that is not a power of two means the modulo subtraction cannot hide behind bit truncation. A run of nine records wraps the pointer, so every age from 0 to 5 is checked against a history kept by the bench, including slots that were never written. A second instance uses the same inputs with `KEEP_HISTORY` = 0, which shows that the no-history build grants and checks permissions like the full build but only ever returns zero. Selectors 6 and 1023 cover the out-of-range cut-off at both ends of the 10-bit field.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic {
    FLT_USER = 1'b0,
    FLT_HYP  = 1'b1
  } flt_lvl_e;

  function automatic int ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bhr_gate.sv
module bhr_gate
  import bhr_pkg::*;
#(
  parameter int          CAUSE_W     = 4,
  parameter logic [3:0]  FAULT_CAUSE = 4'hB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_req_i,
  input  logic               hyp_en_i,
  input  logic               user_mode_i,
  input  logic               user_avail_i,
  output logic               grant_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               fault_hyp_o
);
  logic     hyp_fail, usr_fail, fault_d;
  flt_lvl_e lvl_d, lvl_q;

  // hypervisor level is checked first and takes precedence
  assign hyp_fail = !hyp_en_i;
  assign usr_fail = user_mode_i && !user_avail_i;
  assign grant_o  = !hyp_fail && !usr_fail;
  assign fault_d  = op_req_i && !grant_o;
  assign lvl_d    = hyp_fail ? FLT_HYP : FLT_USER;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      lvl_q   <= FLT_USER;
    end else begin
      fault_o <= fault_d;
      lvl_q   <= fault_d ? lvl_d : FLT_USER;
    end
  end

  assign cause_o     = fault_o ? CAUSE_W'(FAULT_CAUSE) : '0;
  assign fault_hyp_o = (lvl_q == FLT_HYP);
endmodule

// File: rtl/bhr_store.sv
module bhr_store
  import bhr_pkg::*;
#(
  parameter int NUM_ENTRIES  = 16,
  parameter int DATA_W       = 64,
  parameter bit KEEP_HISTORY = 1'b1,
  localparam int IDX_W       = ptr_w(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [DATA_W-1:0] rec_data_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [DATA_W-1:0] word_o
);
  if (KEEP_HISTORY) begin : g_hist
    logic [DATA_W-1:0] mem_q [NUM_ENTRIES];
    logic [IDX_W-1:0]  ptr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
        for (int i = 0; i < NUM_ENTRIES; i++) mem_q[i] <= '0;
      end else if (clr_i) begin
        ptr_q <= '0;
        for (int i = 0; i < NUM_ENTRIES; i++) mem_q[i] <= '0;
      end else if (rec_valid_i) begin
        mem_q[ptr_q] <= rec_data_i;
        ptr_q        <= (ptr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end

    assign ptr_o  = ptr_q;
    assign word_o = mem_q[rd_idx_i];
  end else begin : g_nohist
    logic unused_ok;
    assign unused_ok = ^{clk_i, rst_ni, rec_valid_i, rec_data_i, clr_i, rd_idx_i};
    assign ptr_o  = '0;
    assign word_o = '0;
  end
endmodule

// File: rtl/bhr_read.sv
module bhr_read
  import bhr_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int DATA_W      = 64,
  parameter int SEL_W       = 10,
  localparam int IDX_W      = ptr_w(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [IDX_W-1:0]  ptr_i,
  input  logic              feature_en_i,
  input  logic              alert_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic in_range, zero;
  int   p_v, b_v, i_v;

  assign in_range = (32'(sel_i) < NUM_ENTRIES);
  assign zero     = !in_range || !feature_en_i || alert_en_i;

  // (ptr - (sel+1)) mod N without relying on power-of-two wrap
  always_comb begin
    p_v = int'(ptr_i);
    b_v = int'(sel_i) + 1;
    i_v = 0;
    if (in_range) i_v = (p_v >= b_v) ? (p_v - b_v) : (p_v + NUM_ENTRIES - b_v);
  end
  assign idx_o = IDX_W'(i_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= go_i;
      data_o  <= (go_i && !zero) ? word_i : '0;
    end
  end
endmodule

// File: rtl/branch_hist_buf.sv
module branch_hist_buf
  import bhr_pkg::*;
#(
  parameter int         NUM_ENTRIES  = 16,
  parameter int         DATA_W       = 64,
  parameter int         SEL_W        = 10,
  parameter int         CAUSE_W      = 4,
  parameter logic [3:0] FAULT_CAUSE  = 4'hB,
  parameter bit         KEEP_HISTORY = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rec_valid_i,
  input  logic [DATA_W-1:0]  rec_data_i,
  input  logic               clr_req_i,
  input  logic               rd_req_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  input  logic               user_mode_i,
  input  logic               user_avail_i,
  input  logic               hyp_en_i,
  input  logic               feature_en_i,
  input  logic               alert_en_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o,
  output logic               fault_hyp_o
);
  localparam int IDX_W = ptr_w(NUM_ENTRIES);

  logic              grant, clr_do, rd_go;
  logic [IDX_W-1:0]  ptr, rd_idx;
  logic [DATA_W-1:0] word;

  bhr_gate #(.CAUSE_W(CAUSE_W), .FAULT_CAUSE(FAULT_CAUSE)) u_gate (
    .clk_i, .rst_ni,
    .op_req_i    (clr_req_i || rd_req_i),
    .hyp_en_i, .user_mode_i, .user_avail_i,
    .grant_o     (grant),
    .fault_o,
    .cause_o     (fault_cause_o),
    .fault_hyp_o
  );

  assign clr_do = clr_req_i && grant && feature_en_i;
  assign rd_go  = rd_req_i && grant;

  bhr_store #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .KEEP_HISTORY(KEEP_HISTORY)) u_store (
    .clk_i, .rst_ni, .rec_valid_i, .rec_data_i,
    .clr_i    (clr_do),
    .rd_idx_i (rd_idx),
    .ptr_o    (ptr),
    .word_o   (word)
  );

  bhr_read #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_read (
    .clk_i, .rst_ni,
    .go_i    (rd_go),
    .sel_i   (rd_sel_i),
    .ptr_i   (ptr),
    .feature_en_i, .alert_en_i,
    .word_i  (word),
    .idx_o   (rd_idx),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/branch_hist_buf_chk.sv
module branch_hist_buf_chk #(
  parameter int         NUM_ENTRIES  = 16,
  parameter int         DATA_W       = 64,
  parameter int         SEL_W        = 10,
  parameter int         CAUSE_W      = 4,
  parameter logic [3:0] FAULT_CAUSE  = 4'hB,
  parameter bit         KEEP_HISTORY = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_req_i,
  input logic               rd_req_i,
  input logic [SEL_W-1:0]   rd_sel_i,
  input logic               user_mode_i,
  input logic               user_avail_i,
  input logic               hyp_en_i,
  input logic               feature_en_i,
  input logic               alert_en_i,
  input logic               rd_valid_o,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] fault_cause_o,
  input logic               fault_hyp_o
);
  assert_rd_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));

  assert_fault_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(rd_req_i || clr_req_i) && fault_cause_o == CAUSE_W'(FAULT_CAUSE)));

  assert_fault_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && rd_valid_o));

  assert_hyp_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && $past(!hyp_en_i)) |-> fault_hyp_o);

  assert_user_fault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past((rd_req_i || clr_req_i) && hyp_en_i && user_mode_i && !user_avail_i))
      |-> (fault_o && !fault_hyp_o));

  assert_sel_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(32'(rd_sel_i) >= NUM_ENTRIES)) |-> (rd_data_o == '0));

  assert_zero_cond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(!feature_en_i || alert_en_i)) |-> (rd_data_o == '0));

  if (!KEEP_HISTORY) begin : g_nohist
    assert_nohist_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> (rd_data_o == '0));
  end
endmodule

bind branch_hist_buf branch_hist_buf_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W),
  .CAUSE_W(CAUSE_W), .FAULT_CAUSE(FAULT_CAUSE), .KEEP_HISTORY(KEEP_HISTORY)
) u_chk (.*);

// File: tb/branch_hist_buf_bench.sv
module branch_hist_buf_bench;
  localparam int NE = 6;
  localparam int DW = 64;
  localparam logic [3:0] CAUSE = 4'hB;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          rec_valid = 0, clr_req = 0, rd_req = 0;
  logic [DW-1:0] rec_data = '0;
  logic [9:0]    rd_sel = '0;
  logic          user_mode = 0, user_avail = 0, hyp_en = 1, feature_en = 1, alert_en = 0;

  logic          rd_valid, fault, fault_hyp, rd_valid2, fault2, fault_hyp2;
  logic [DW-1:0] rd_data, rd_data2;
  logic [3:0]    fault_cause, fault_cause2;

  branch_hist_buf #(.NUM_ENTRIES(NE), .FAULT_CAUSE(CAUSE)) u_branch_hist_buf (
    .clk_i(clk), .rst_ni, .rec_valid_i(rec_valid), .rec_data_i(rec_data),
    .clr_req_i(clr_req), .rd_req_i(rd_req), .rd_sel_i(rd_sel),
    .user_mode_i(user_mode), .user_avail_i(user_avail), .hyp_en_i(hyp_en),
    .feature_en_i(feature_en), .alert_en_i(alert_en),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .fault_o(fault),
    .fault_cause_o(fault_cause), .fault_hyp_o(fault_hyp));

  branch_hist_buf #(.NUM_ENTRIES(NE), .FAULT_CAUSE(CAUSE), .KEEP_HISTORY(1'b0)) u_branch_hist_buf_nh (
    .clk_i(clk), .rst_ni, .rec_valid_i(rec_valid), .rec_data_i(rec_data),
    .clr_req_i(clr_req), .rd_req_i(rd_req), .rd_sel_i(rd_sel),
    .user_mode_i(user_mode), .user_avail_i(user_avail), .hyp_en_i(hyp_en),
    .feature_en_i(feature_en), .alert_en_i(alert_en),
    .rd_valid_o(rd_valid2), .rd_data_o(rd_data2), .fault_o(fault2),
    .fault_cause_o(fault_cause2), .fault_hyp_o(fault_hyp2));

  int checks = 0, errors = 0;
  logic [DW-1:0] hist [64];
  int cnt = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_sel(int sel);
    if (sel >= NE || sel >= cnt) return '0;
    return hist[cnt-1-sel];
  endfunction

  // one clock: inputs set at negedge, outputs sampled at the next negedge
  task automatic cyc(logic rv, logic [DW-1:0] d, logic c, logic r, logic [9:0] s);
    rec_valid = rv; rec_data = d; clr_req = c; rd_req = r; rd_sel = s;
    @(posedge clk); @(negedge clk);
    rec_valid = 0; clr_req = 0; rd_req = 0;
  endtask

  task automatic record(logic [DW-1:0] d);
    cyc(1, d, 0, 0, 0);
    hist[cnt] = d; cnt++;
  endtask

  task automatic rd_chk(string req, int sel, logic [DW-1:0] exp);
    cyc(0, '0, 0, 1, 10'(sel));
    chk({req, " valid"}, 64'(rd_valid), 64'(1));
    chk({req, " data"}, rd_data, exp);
    chk({req, " nofault"}, 64'(fault), 64'(0));
  endtask

  task automatic t_reset;
    chk("R1 valid low", 64'(rd_valid), 0);
    chk("R1 fault low", 64'(fault), 0);
    for (int s = 0; s < NE; s++) rd_chk("R1 zero entries", s, '0);
  endtask

  task automatic t_record;
    for (int i = 0; i < 4; i++) record(64'hA000_0000_0000_0000 + 64'(i));
    rd_chk("R2 newest", 0, 64'hA000_0000_0000_0003);
    chk("R4 valid drops", 64'(rd_valid), 64'(1));
    @(posedge clk); @(negedge clk);
    chk("R4 valid one cycle", 64'(rd_valid), 0);
    rd_chk("R3 oldest", 3, 64'hA000_0000_0000_0000);
    rd_chk("R3 unwritten", 4, '0);
  endtask

  task automatic t_wrap;
    for (int i = 4; i < 9; i++) record(64'hA000_0000_0000_0000 + 64'(i));
    for (int s = 0; s < NE; s++) rd_chk("R3 wrapped age", s, expect_sel(s));
    rd_chk("R2 newest after wrap", 0, 64'hA000_0000_0000_0008);
  endtask

  task automatic t_range;
    rd_chk("R5 sel=N", NE, '0);
    rd_chk("R5 sel=1023", 1023, '0);
  endtask

  task automatic t_zero_cond;
    feature_en = 0; rd_chk("R6 feature off", 0, '0); feature_en = 1;
    alert_en = 1;   rd_chk("R6 alert on", 0, '0);    alert_en = 0;
    rd_chk("R6 restored", 0, expect_sel(0));
  endtask

  task automatic t_clear;
    feature_en = 0;
    cyc(0, '0, 1, 0, 0);
    chk("R7 no fault feature off", 64'(fault), 0);
    feature_en = 1;
    rd_chk("R7 intact", 0, expect_sel(0));
    cyc(0, '0, 1, 0, 0); cnt = 0;
    chk("R7 no fault clear", 64'(fault), 0);
    for (int s = 0; s < NE; s++) rd_chk("R7 cleared", s, '0);
    record(64'hB0B0);
    record(64'hB1B1);
    rd_chk("R7 after clear newest", 0, 64'hB1B1);
    rd_chk("R7 after clear older", 1, 64'hB0B0);
    rd_chk("R7 after clear unwritten", 2, '0);
  endtask

  task automatic t_clr_vs_rec;
    cyc(1, 64'hDEAD, 1, 0, 0); cnt = 0;
    rd_chk("R8 clear wins", 0, '0);
    record(64'hC0C0);
    rd_chk("R8 record after", 0, 64'hC0C0);
  endtask

  task automatic t_hyp_fault;
    hyp_en = 0;
    cyc(0, '0, 0, 1, 0);
    chk("R9 fault", 64'(fault), 1);
    chk("R9 cause", 64'(fault_cause), 64'(CAUSE));
    chk("R9 hyp level", 64'(fault_hyp), 1);
    chk("R9 read blocked", 64'(rd_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 pulse", 64'(fault), 0);
    cyc(0, '0, 1, 0, 0);
    chk("R9 clear fault", 64'(fault), 1);
    user_mode = 1; user_avail = 0;
    cyc(0, '0, 0, 1, 0);
    chk("R10 both fail hyp first", 64'(fault_hyp), 1);
    user_mode = 0; hyp_en = 1;
    rd_chk("R9 clear blocked", 0, 64'hC0C0);
  endtask

  task automatic t_user_fault;
    user_mode = 1; user_avail = 0;
    cyc(0, '0, 1, 0, 0);
    chk("R10 fault", 64'(fault), 1);
    chk("R10 user level", 64'(fault_hyp), 0);
    chk("R10 cause", 64'(fault_cause), 64'(CAUSE));
    cyc(0, '0, 0, 1, 0);
    chk("R10 read blocked", 64'(rd_valid), 0);
    user_avail = 1;
    rd_chk("R10 user allowed, clear blocked", 0, 64'hC0C0);
    user_mode = 0; user_avail = 0;
  endtask

  task automatic t_nohist;
    cyc(0, '0, 0, 1, 0);
    chk("R11 valid", 64'(rd_valid2), 1);
    chk("R11 zero", rd_data2, '0);
    chk("R11 no fault", 64'(fault2), 0);
    cyc(0, '0, 1, 0, 0);
    chk("R11 clear no fault", 64'(fault2), 0);
    cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_record;
    t_wrap;
    t_range;
    t_zero_cond;
    t_clear;
    t_clr_vs_rec;
    t_hyp_fault;
    t_user_fault;
    t_nohist;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule